// File: doc/BRIEF.md
# Prioritized Triple Transmit Buffer Manager

This block holds three outgoing message buffers for a CAN-style controller, so that one buffer can be on the wire, a second can wait its turn and the CPU can refill the third. The CPU talks to it over a small register bus. It sees one empty bit per buffer, a select register, and a single shared window. Through that window it reaches the 13-byte message image, the 8-bit local priority and the 2-byte transmit timestamp of whichever buffer is selected.

When the CPU has filled a buffer, it writes a one to that buffer's empty bit, which clears the bit and marks the buffer ready. Whenever the serializer is idle, the block picks the ready buffer with the best local priority. It presents that buffer's image to a serializer stub and holds it until the stub reports completion. On completion the buffer becomes empty again and captures a free-running 16-bit timer as its timestamp. An enabled empty bit raises the interrupt.

Top module: `tx_triple_buf`

## Requirements
- R1: After reset all three empty bits read 1, the select register reads 0, the interrupt enable register reads 0, `irq` is low and `tx_valid` is low.
- R2: A write to the select register (address 0x02) keeps only the lowest-indexed written bit (bit n = buffer n) whose buffer is empty. A read returns that one-hot value, or 0 if no written bit belongs to an empty buffer.
- R3: Window bytes at addresses 0x10 to 0x1C (image bytes 0 to 12) and 0x1D (priority) write to and read from the selected buffer only. With the select register at 0, window writes change no buffer and window reads return 0.
- R4: Writing 1 to bit n of the flag register (address 0x00) clears that buffer's empty bit and marks it ready. Writing 0 to a bit leaves it unchanged.
- R5: Among ready buffers, the one with the numerically lowest priority value is sent first. Equal priorities go to the lowest buffer index.
- R6: While `tx_valid` is high, `tx_buf` names the chosen buffer, and `tx_frame[8k+7:8k]` carries its image byte k for k = 0 to 12.
- R7: A `tx_done` pulse during a transmission sets that buffer's empty bit and drops `tx_valid` at the same clock edge.
- R8: On completion the buffer's timestamp (0x1E high byte, 0x1F low byte) captures a timer that advances by one each clock. The difference between two buffers' timestamps therefore equals the number of cycles between their completions.
- R9: Window writes to the buffer currently being transmitted are ignored.
- R10: `irq` is high exactly when some buffer is empty and its bit in the interrupt enable register (address 0x01) is set.
- R11: A new choice is made only when no transmission is in progress. A better-priority buffer made ready during a transmission does not replace the buffer being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Transmit-empty interrupt |
| tx_valid | output | 1 | A buffer is handed to the serializer |
| tx_buf | output | 2 | Index of the buffer being sent |
| tx_frame | output | 104 | Image of the buffer being sent |
| tx_done | input | 1 | Serializer completion pulse |

## Verification
On every cycle, the assertions check four things. The select register stays one-hot or zero. The buffer being sent is never marked empty. The presented frame stays frozen from one cycle to the next until completion. A completion always returns its buffer to empty and ends the transmission. Other properties need a sequence of stimulus and only the directed scenarios can show them: the send order chosen from priorities and ties, refusal to preempt, the filtering of the select write, and timestamp spacing.

// File: rtl/tx_triple_buf.sv
module tx_triple_buf #(
  parameter int NUM_BUF   = 3,
  parameter int IMG_BYTES = 13,
  parameter int ADDR_W    = 5,
  parameter int TS_W      = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_en,
  input  logic                   bus_wr,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [7:0]             bus_wdata,
  output logic [7:0]             bus_rdata,
  output logic                   irq,
  output logic                   tx_valid,
  output logic [1:0]             tx_buf,
  output logic [8*IMG_BYTES-1:0] tx_frame,
  input  logic                   tx_done
);
  localparam int IDX_W    = $clog2(NUM_BUF);
  localparam int SLOTS    = IMG_BYTES + 1;
  localparam int WIN_BASE = 16;
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(2);

  logic [NUM_BUF-1:0] empty_q, ien_q, sel_q, sel_nxt, done_mask, w1c;
  logic [7:0]         mem [NUM_BUF][SLOTS];
  logic [TS_W-1:0]    ts  [NUM_BUF];
  logic [TS_W-1:0]    timer_q;
  logic               active_q;
  logic [IDX_W-1:0]   act_idx, best_idx, sel_idx;
  logic               any_ready;
  logic [7:0]         best_p;

  wire                 wr_hit  = bus_en && bus_wr;
  wire                 in_win  = bus_addr >= ADDR_W'(WIN_BASE);
  wire [ADDR_W-2:0]    win_off = bus_addr[ADDR_W-2:0];
  wire                 sel_any = |sel_q;
  wire                 blocked = active_q && (sel_idx == act_idx);
  wire                 win_we  = wr_hit && in_win && sel_any && !blocked &&
                                 (int'(win_off) < SLOTS);
  wire                 finish  = active_q && tx_done;

  assign irq      = |(empty_q & ien_q);
  assign tx_valid = active_q;
  assign tx_buf   = 2'(act_idx);
  assign w1c      = (wr_hit && bus_addr == A_FLAG) ? bus_wdata[NUM_BUF-1:0] : '0;

  always_comb begin
    sel_idx = '0;
    sel_nxt = '0;
    done_mask = '0;
    for (int i = NUM_BUF - 1; i >= 0; i--) begin
      if (sel_q[i]) sel_idx = IDX_W'(i);
      if (bus_wdata[i] && empty_q[i]) begin
        sel_nxt = '0;
        sel_nxt[i] = 1'b1;
      end
    end
    if (finish) done_mask[act_idx] = 1'b1;
  end

  always_comb begin
    any_ready = 1'b0;
    best_idx  = '0;
    best_p    = 8'hFF;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (!empty_q[i] && (!any_ready || mem[i][IMG_BYTES] < best_p)) begin
        any_ready = 1'b1;
        best_idx  = IDX_W'(i);
        best_p    = mem[i][IMG_BYTES];
      end
    end
  end

  always_comb begin
    for (int k = 0; k < IMG_BYTES; k++) tx_frame[8*k +: 8] = mem[act_idx][k];
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_FLAG)      bus_rdata[NUM_BUF-1:0] = empty_q;
    else if (bus_addr == A_IEN)  bus_rdata[NUM_BUF-1:0] = ien_q;
    else if (bus_addr == A_SEL)  bus_rdata[NUM_BUF-1:0] = sel_q;
    else if (in_win && sel_any) begin
      if (int'(win_off) < SLOTS)       bus_rdata = mem[sel_idx][win_off];
      else if (int'(win_off) == SLOTS) bus_rdata = ts[sel_idx][TS_W-1 -: 8];
      else                             bus_rdata = ts[sel_idx][7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q  <= '1;
      ien_q    <= '0;
      sel_q    <= '0;
      timer_q  <= '0;
      active_q <= 1'b0;
      act_idx  <= '0;
      for (int b = 0; b < NUM_BUF; b++) begin
        ts[b] <= '0;
        for (int k = 0; k < SLOTS; k++) mem[b][k] <= '0;
      end
    end else begin
      timer_q <= timer_q + 1'b1;
      empty_q <= (empty_q & ~w1c) | done_mask;
      if (wr_hit && bus_addr == A_IEN) ien_q <= bus_wdata[NUM_BUF-1:0];
      if (wr_hit && bus_addr == A_SEL) sel_q <= sel_nxt;
      if (win_we) mem[sel_idx][win_off] <= bus_wdata;
      if (finish) begin
        ts[act_idx] <= timer_q;
        active_q    <= 1'b0;
      end else if (!active_q && any_ready) begin
        active_q <= 1'b1;
        act_idx  <= best_idx;
      end
    end
  end

  assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_q));

  assert_sending_not_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !empty_q[act_idx]);

  assert_done_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_done) |=> (!tx_valid && empty_q[$past(act_idx)]));

  assert_frame_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_done) |=> (tx_valid && $stable(tx_frame) && $stable(tx_buf)));
endmodule

// File: tb/test_tx_triple_buf.sv
module test_tx_triple_buf;
  logic         clk = 0, rst_n = 0;
  logic         bus_en = 0, bus_wr = 0, tx_done = 0;
  logic [4:0]   bus_addr = '0;
  logic [7:0]   bus_wdata = '0, bus_rdata;
  logic         irq, tx_valid;
  logic [1:0]   tx_buf;
  logic [103:0] tx_frame;
  int n_tests = 0, n_fail = 0, cyc = 0, stamp = 0;
  int stamps [3];

  tx_triple_buf i_tx_triple_buf (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .tx_valid(tx_valid), .tx_buf(tx_buf), .tx_frame(tx_frame),
    .tx_done(tx_done));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_en = 1; bus_wr = 1; bus_addr = 5'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_en = 0; bus_wr = 0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    bus_addr = 5'(a);
    #1 d = int'(bus_rdata);
  endtask

  task automatic load(input int b, input int base, input int prio);
    wr(2, 1 << b);
    for (int k = 0; k < 13; k++) wr(16 + k, base + k);
    wr(29, prio);
  endtask

  task automatic wait_tx();
    for (int i = 0; i < 20 && !tx_valid; i++) @(negedge clk);
  endtask

  task automatic done_pulse(input int b);
    int v;
    @(negedge clk);
    tx_done = 1; stamp = cyc; stamps[b] = cyc;
    @(negedge clk);
    tx_done = 0;
    chk(tx_valid == 0, "R7 valid drop", int'(tx_valid), 0);
    rd(0, v);
    chk(v[b] == 1, "R7 empty set", v, 1 << b);
  endtask

  task automatic t_reset();
    int v;
    rd(0, v); chk(v == 7, "R1 flags", v, 7);
    rd(2, v); chk(v == 0, "R1 select", v, 0);
    rd(1, v); chk(v == 0, "R1 enable", v, 0);
    chk(irq == 0 && tx_valid == 0, "R1 outputs", {irq, tx_valid}, 0);
  endtask

  task automatic t_window_unselected();
    int v;
    wr(2, 0);
    wr(16, 8'h5A);
    wr(2, 1);
    rd(16, v); chk(v == 0, "R3 write without select ignored", v, 0);
    wr(2, 0);
    rd(16, v); chk(v == 0, "R3 read without select", v, 0);
  endtask

  task automatic t_select_filter();
    int v;
    wr(2, 6); rd(2, v); chk(v == 2, "R2 lowest written empty bit", v, 2);
    wr(0, 2); rd(0, v); chk(v == 5, "R4 flag w1c", v, 5);
    wr(2, 2); rd(2, v); chk(v == 0, "R2 non-empty rejected", v, 0);
    wr(2, 3); rd(2, v); chk(v == 1, "R2 skip non-empty bit", v, 1);
    wait_tx();
    done_pulse(1);
  endtask

  task automatic t_single_send_protect();
    int v;
    logic [103:0] exp;
    load(1, 8'h20, 5);
    wr(0, 0); rd(0, v); chk(v == 7, "R4 zero write no effect", v, 7);
    rd(18, v); chk(v == 8'h22, "R3 window readback", v, 8'h22);
    wr(0, 2);
    wait_tx();
    for (int k = 0; k < 13; k++) exp[8*k +: 8] = 8'(8'h20 + k);
    chk(tx_valid && tx_buf == 1, "R6 buffer index", int'(tx_buf), 1);
    chk(tx_frame == exp, "R6 frame bytes", int'(tx_frame[31:0]), int'(exp[31:0]));
    wr(16, 8'hEE);
    rd(16, v); chk(v == 8'h20, "R9 busy buffer write ignored", v, 8'h20);
    chk(tx_frame == exp, "R9 frame unchanged", int'(tx_frame[7:0]), 8'h20);
    done_pulse(1);
  endtask

  task automatic t_priority_order();
    int v, a, b;
    load(0, 8'h40, 9);
    load(1, 8'h50, 3);
    load(2, 8'h60, 7);
    wr(0, 7);
    wait_tx(); chk(tx_buf == 1, "R5 lowest value first", int'(tx_buf), 1);
    done_pulse(1);
    wait_tx(); chk(tx_buf == 2, "R5 second", int'(tx_buf), 2);
    repeat (4) @(negedge clk);
    done_pulse(2);
    wait_tx(); chk(tx_buf == 0, "R5 third", int'(tx_buf), 0);
    done_pulse(0);
    wr(2, 2); rd(30, a); rd(31, v); a = (a << 8) | v;
    wr(2, 4); rd(30, b); rd(31, v); b = (b << 8) | v;
    chk(b - a == stamps[2] - stamps[1], "R8 timestamp spacing", b - a, stamps[2] - stamps[1]);
  endtask

  task automatic t_tie();
    load(0, 1, 4); load(1, 2, 4); load(2, 3, 4);
    wr(0, 7);
    for (int i = 0; i < 3; i++) begin
      wait_tx(); chk(int'(tx_buf) == i, "R5 tie lowest index", int'(tx_buf), i);
      done_pulse(i);
    end
  endtask

  task automatic t_no_preempt_irq();
    load(0, 8'h70, 10);
    load(2, 8'h80, 1);
    wr(1, 1);
    chk(irq == 1, "R10 enabled empty raises irq", int'(irq), 1);
    wr(0, 1);
    wait_tx();
    chk(irq == 0, "R10 irq low when enabled buffer busy", int'(irq), 0);
    wr(0, 4);
    repeat (3) @(negedge clk);
    chk(tx_valid && tx_buf == 0, "R11 no preemption", int'(tx_buf), 0);
    done_pulse(0);
    chk(irq == 1, "R10 irq after completion", int'(irq), 1);
    wait_tx(); chk(tx_buf == 2, "R11 next after idle", int'(tx_buf), 2);
    done_pulse(2);
    wr(1, 0);
    chk(irq == 0, "R10 masked", int'(irq), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_window_unselected();
    t_select_filter();
    t_single_send_protect();
    t_priority_order();
    t_tie();
    t_no_preempt_irq();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule